// File: doc/BRIEF.md
# I2C Controller Event Vector Encoder

This block gathers the event indications of an I2C controller's bus engine and presents them to software in three ways: a 16-bit status word, a 7-bit enable mask and a vector register. The vector register returns a 3-bit code for the most urgent event that is both pending and enabled, or zero when there is none. A single interrupt line is high while any enabled event is pending.

The bus engine signals five one-cycle events: arbitration lost, NACK received, access ready, stop seen and addressed as slave. Each is latched in a sticky flag. It also drives four levels: receive ready, transmit ready, receive shifter full and bus busy, and the status word shows these directly. Software can clear sticky flags by writing ones to the status word. A simpler way to handle the block is to read the vector register in a loop: each read acknowledges the sticky event it reports, and the loop ends when the read returns zero. The register port is a plain read/write strobe interface. Read data is combinational and valid in the cycle the read strobe is high. A read's side effect takes place at the clock edge that ends that cycle.

Top module: `ivec_ctrl`

## Requirements
- R1: After synchronous reset all sticky flags and the mask are zero, the vector reads 0 and irq is low.
- R2: An event pulse sets its sticky status bit at the next clock edge. The positions are: arbitration lost bit 0, NACK bit 1, access ready bit 2, stop seen bit 5, addressed as slave bit 9. The level inputs appear in the same cycle at these positions: receive ready bit 3, transmit ready bit 4, receive shifter full bit 11, bus busy bit 12. All other status bits read 0.
- R3: A write to the status word (offset 0x08) clears each sticky bit written as 1 and leaves bits written as 0 unchanged. An event pulse in the same cycle wins over the clear.
- R4: The mask register (offset 0x04) holds 7 bits. Each bit enables one event: bit 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as slave. Bits 15:7 read 0 and ignore writes.
- R5: The vector register (offset 0x28) returns the lowest code among the pending, enabled events. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as slave 7. It returns 0 when no such event exists.
- R6: A masked event still sets its status bit but never appears in the vector and never raises irq.
- R7: Reading the vector clears the sticky flag of the event it reported. A reported receive-ready or transmit-ready level is not cleared and is reported again.
- R8: irq is high exactly when some pending event has its mask bit set.
- R9: Reads of unmapped offsets return 0. Writes to the vector offset or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_nack | input | 1 | NACK received pulse |
| evt_acc_ready | input | 1 | Access ready pulse |
| evt_stop_seen | input | 1 | Stop condition seen pulse |
| evt_addr_slave | input | 1 | Addressed as slave pulse |
| lvl_rx_ready | input | 1 | Receive data ready level |
| lvl_tx_ready | input | 1 | Transmit data ready level |
| lvl_rx_full | input | 1 | Receive shifter full level |
| lvl_busy | input | 1 | Bus busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Errors in the sticky flags show at the ports one cycle after the stimulus. A flag that was lost, stuck or cleared by mistake changes the next status read, the next vector code, and irq in that same cycle. A wrong priority chain shows on the first vector read with two or more events pending. A wrong read-acknowledge shows on the read that follows, which repeats the old code or skips a code. The bench therefore drains several events at once, mixes level and sticky sources, and reads back after every write, so each fault is visible within one or two register accesses.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 8;
    localparam int NUM_EV  = 7;
    localparam int CODE_W  = $clog2(NUM_EV + 1);
    localparam int NUM_STK = 5;

    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h28;

    // status word bit positions
    localparam int SB_AL     = 0;
    localparam int SB_NACK   = 1;
    localparam int SB_ARDY   = 2;
    localparam int SB_RXRDY  = 3;
    localparam int SB_TXRDY  = 4;
    localparam int SB_STOP   = 5;
    localparam int SB_SLAVE  = 9;
    localparam int SB_RXFULL = 11;
    localparam int SB_BUSY   = 12;

    // sticky flag index order
    localparam int SK_AL    = 0;
    localparam int SK_NACK  = 1;
    localparam int SK_ARDY  = 2;
    localparam int SK_STOP  = 3;
    localparam int SK_SLAVE = 4;

    typedef enum logic [CODE_W-1:0] {
        VC_NONE  = 3'd0,
        VC_AL    = 3'd1,
        VC_NACK  = 3'd2,
        VC_ARDY  = 3'd3,
        VC_RXRDY = 3'd4,
        VC_TXRDY = 3'd5,
        VC_STOP  = 3'd6,
        VC_SLAVE = 3'd7
    } vec_code_e;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic tx_ready;
        logic rx_ready;
    } level_t;
endpackage

// File: rtl/ivec_flags.sv
module ivec_flags #(
    parameter int N = ivec_pkg::NUM_STK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] flag_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_i[i])
                    q <= 1'b1;
                else if (w1c_i[i] || ack_i[i])
                    q <= 1'b0;
            end
            assign flag_o[i] = q;
        end
    endgenerate
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio #(
    parameter int N  = ivec_pkg::NUM_EV,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [CW-1:0] code_o,
    output logic          any_o
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant_o[i]   = req_i[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | req_i[i];
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) code_o = code_o | CW'(i + 1);
        end
    end

    assign any_o = blocked[N];
endmodule

// File: rtl/ivec_regs.sv
module ivec_regs
    import ivec_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W,
    parameter int NE = NUM_EV,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] status_i,
    input  logic [CW-1:0] code_i,
    output logic [NE-1:0] mask_o,
    output logic          stat_wr_o,
    output logic          vec_rd_o,
    output logic [DW-1:0] rdata_o
);
    logic [NE-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_i && addr_i == OFS_MASK)
            mask_q <= wdata_i[NE-1:0];
    end

    assign mask_o    = mask_q;
    assign stat_wr_o = wr_i && (addr_i == OFS_STAT);
    assign vec_rd_o  = rd_i && (addr_i == OFS_VEC);

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_MASK: rdata_o[NE-1:0] = mask_q;
            OFS_STAT: rdata_o         = status_i;
            OFS_VEC:  rdata_o[CW-1:0] = code_i;
            default:  rdata_o         = '0;
        endcase
    end
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_arb_lost,
    input  logic              evt_nack,
    input  logic              evt_acc_ready,
    input  logic              evt_stop_seen,
    input  logic              evt_addr_slave,
    input  logic              lvl_rx_ready,
    input  logic              lvl_tx_ready,
    input  logic              lvl_rx_full,
    input  logic              lvl_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    level_t               lvl;
    logic [NUM_STK-1:0]   stk_set, stk_w1c, stk_ack, stk_q;
    logic [NUM_EV-1:0]    pending, enabled, grant, mask;
    logic [CODE_W-1:0]    code;
    logic [REG_W-1:0]     status_word;
    logic                 stat_wr, vec_rd, any_hit;

    assign lvl = '{busy: lvl_busy, rx_full: lvl_rx_full,
                   tx_ready: lvl_tx_ready, rx_ready: lvl_rx_ready};

    always_comb begin
        stk_set           = '0;
        stk_set[SK_AL]    = evt_arb_lost;
        stk_set[SK_NACK]  = evt_nack;
        stk_set[SK_ARDY]  = evt_acc_ready;
        stk_set[SK_STOP]  = evt_stop_seen;
        stk_set[SK_SLAVE] = evt_addr_slave;

        stk_w1c = '0;
        if (stat_wr) begin
            stk_w1c[SK_AL]    = reg_wdata[SB_AL];
            stk_w1c[SK_NACK]  = reg_wdata[SB_NACK];
            stk_w1c[SK_ARDY]  = reg_wdata[SB_ARDY];
            stk_w1c[SK_STOP]  = reg_wdata[SB_STOP];
            stk_w1c[SK_SLAVE] = reg_wdata[SB_SLAVE];
        end

        // events indexed by code-1
        pending = {stk_q[SK_SLAVE], stk_q[SK_STOP], lvl.tx_ready,
                   lvl.rx_ready, stk_q[SK_ARDY], stk_q[SK_NACK], stk_q[SK_AL]};

        stk_ack = '0;
        if (vec_rd) begin
            stk_ack[SK_AL]    = grant[int'(VC_AL) - 1];
            stk_ack[SK_NACK]  = grant[int'(VC_NACK) - 1];
            stk_ack[SK_ARDY]  = grant[int'(VC_ARDY) - 1];
            stk_ack[SK_STOP]  = grant[int'(VC_STOP) - 1];
            stk_ack[SK_SLAVE] = grant[int'(VC_SLAVE) - 1];
        end

        status_word            = '0;
        status_word[SB_AL]     = stk_q[SK_AL];
        status_word[SB_NACK]   = stk_q[SK_NACK];
        status_word[SB_ARDY]   = stk_q[SK_ARDY];
        status_word[SB_RXRDY]  = lvl.rx_ready;
        status_word[SB_TXRDY]  = lvl.tx_ready;
        status_word[SB_STOP]   = stk_q[SK_STOP];
        status_word[SB_SLAVE]  = stk_q[SK_SLAVE];
        status_word[SB_RXFULL] = lvl.rx_full;
        status_word[SB_BUSY]   = lvl.busy;
    end

    assign enabled = pending & mask;

    ivec_flags #(.N(NUM_STK)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (stk_set),
        .w1c_i  (stk_w1c),
        .ack_i  (stk_ack),
        .flag_o (stk_q)
    );

    ivec_prio #(.N(NUM_EV), .CW(CODE_W)) u_prio (
        .req_i   (enabled),
        .grant_o (grant),
        .code_o  (code),
        .any_o   (any_hit)
    );

    ivec_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .status_i  (status_word),
        .code_i    (code),
        .mask_o    (mask),
        .stat_wr_o (stat_wr),
        .vec_rd_o  (vec_rd),
        .rdata_o   (reg_rdata)
    );

    assign irq = any_hit;
endmodule

// File: rtl/ivec_ctrl_chk.sv
module ivec_ctrl_chk
    import ivec_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                evt_al,
    input logic                evt_ardy,
    input logic                wr,
    input logic                rd,
    input logic [ADDR_W-1:0]   addr,
    input logic [REG_W-1:0]    wdata,
    input logic                irq,
    input logic [NUM_EV-1:0]   mask,
    input logic [NUM_EV-1:0]   grant,
    input logic [CODE_W-1:0]   code,
    input logic [NUM_STK-1:0]  flags
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq && flags == '0 && mask == '0));

    assert_al_latch_R2: assert property (@(posedge clk) disable iff (rst)
        evt_al |=> flags[SK_AL]);

    assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_STAT && wdata[SB_ARDY] && !evt_ardy) |=> !flags[SK_ARDY]);

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_masked_hidden_R6: assert property (@(posedge clk) disable iff (rst)
        (grant & ~mask) == '0);

    assert_read_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == OFS_VEC && code == CODE_W'(1) && !evt_al) |=> !flags[SK_AL]);

    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (rst)
        irq == (code != '0));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == OFS_MASK) |=> $stable(mask));
endmodule

bind ivec_ctrl ivec_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_al   (evt_arb_lost),
    .evt_ardy (evt_acc_ready),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .irq      (irq),
    .mask     (mask),
    .grant    (grant),
    .code     (code),
    .flags    (stk_q)
);

// File: tb/ivec_ctrl_test.sv
`timescale 1ns/1ps
module ivec_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        e_al = 0, e_nack = 0, e_ardy = 0, e_stop = 0, e_slave = 0;
    logic        l_rx = 0, l_tx = 0, l_full = 0, l_busy = 0;
    logic        wr = 0, rd = 0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

    always #4 clk = ~clk;

    ivec_ctrl uut (
        .clk(clk), .rst(rst),
        .evt_arb_lost(e_al), .evt_nack(e_nack), .evt_acc_ready(e_ardy),
        .evt_stop_seen(e_stop), .evt_addr_slave(e_slave),
        .lvl_rx_ready(l_rx), .lvl_tx_ready(l_tx), .lvl_rx_full(l_full), .lvl_busy(l_busy),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq)
    );

    // monitor: compares every read against the scoreboard
    always @(negedge clk) begin
        if (rd) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: actual=%h expected=none", rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    bad++;
                    $display("FAIL %s: read %h actual=%h expected=%h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd = 1'b1;
        tick();
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = 16'h0000;
    endtask

    task automatic chk_irq(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_exp(A_STAT, 16'h0000, "R1");
        rd_exp(A_MASK, 16'h0000, "R1");
        rd_exp(A_VEC,  16'h0000, "R1");

        // R4 mask width
        wr_reg(A_MASK, 16'hFFFF);
        rd_exp(A_MASK, 16'h007F, "R4");

        // R2 / R5 / R7 / R8 single event
        e_al = 1; tick(); e_al = 0;
        rd_exp(A_STAT, 16'h0001, "R2");
        chk_irq(1'b1, "R8");
        rd_exp(A_VEC, 16'h0001, "R5");
        rd_exp(A_STAT, 16'h0000, "R7");
        rd_exp(A_VEC, 16'h0000, "R5");
        chk_irq(1'b0, "R8");

        // R5 / R7 drain loop with three events
        e_nack = 1; e_stop = 1; e_slave = 1; tick();
        e_nack = 0; e_stop = 0; e_slave = 0;
        rd_exp(A_STAT, 16'h0222, "R2");
        rd_exp(A_VEC, 16'h0002, "R5");
        rd_exp(A_VEC, 16'h0006, "R7");
        rd_exp(A_VEC, 16'h0007, "R7");
        rd_exp(A_VEC, 16'h0000, "R7");

        // R2 / R7 level sources
        l_rx = 1; l_full = 1; l_busy = 1; #1;
        rd_exp(A_STAT, 16'h1808, "R2");
        rd_exp(A_VEC, 16'h0004, "R7");
        rd_exp(A_VEC, 16'h0004, "R7");
        l_tx = 1; #1;
        rd_exp(A_VEC, 16'h0004, "R5");
        l_rx = 0; #1;
        rd_exp(A_VEC, 16'h0005, "R5");
        e_ardy = 1; tick(); e_ardy = 0;
        rd_exp(A_VEC, 16'h0003, "R5");
        rd_exp(A_VEC, 16'h0005, "R7");
        l_tx = 0; l_full = 0; l_busy = 0; #1;
        chk_irq(1'b0, "R8");

        // R3 write-one-to-clear
        e_ardy = 1; e_stop = 1; tick(); e_ardy = 0; e_stop = 0;
        wr_reg(A_STAT, 16'h0000);
        rd_exp(A_STAT, 16'h0024, "R3");
        wr_reg(A_STAT, 16'h0004);
        rd_exp(A_STAT, 16'h0020, "R3");
        wr_reg(A_STAT, 16'h0020);
        rd_exp(A_STAT, 16'h0000, "R3");
        // R3 pulse wins over clear in same cycle
        e_ardy = 1; addr = A_STAT; wdata = 16'h0004; wr = 1; tick();
        e_ardy = 0; wr = 0; wdata = 16'h0000;
        rd_exp(A_STAT, 16'h0004, "R3");
        wr_reg(A_STAT, 16'hFFFF);
        rd_exp(A_STAT, 16'h0000, "R3");

        // R6 masked event
        wr_reg(A_MASK, 16'h007E);
        e_al = 1; tick(); e_al = 0;
        rd_exp(A_STAT, 16'h0001, "R6");
        rd_exp(A_VEC, 16'h0000, "R6");
        chk_irq(1'b0, "R6");
        rd_exp(A_STAT, 16'h0001, "R6");
        wr_reg(A_MASK, 16'h007F);
        chk_irq(1'b1, "R8");
        rd_exp(A_VEC, 16'h0001, "R6");

        // R9 unmapped and vector writes
        rd_exp(8'h10, 16'h0000, "R9");
        e_slave = 1; tick(); e_slave = 0;
        wr_reg(A_VEC, 16'hFFFF);
        wr_reg(8'h30, 16'hFFFF);
        rd_exp(A_MASK, 16'h007F, "R9");
        rd_exp(A_STAT, 16'h0200, "R9");
        rd_exp(A_VEC, 16'h0007, "R9");
        rd_exp(A_VEC, 16'h0000, "R7");

        // R1 reset again clears state
        e_nack = 1; tick(); e_nack = 0;
        rst = 1; tick(); rst = 0;
        chk_irq(1'b0, "R1");
        rd_exp(A_STAT, 16'h0000, "R1");
        rd_exp(A_MASK, 16'h0000, "R1");

        tick();
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d leftover expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule